// File: doc/BRIEF.md
# Transceiver Operating State Sequencer

This block steps a radio transceiver through its operating states under command from a register port. Software writes a 5-bit state command into the command register and reads the current operating state back from the status register. A requested change does not take effect at once: for a programmable settle time the status reports a dedicated in-transition code, and then it reports the new state.

Two activity phases are modelled on top of the steady states. A transmit command issued while the transceiver is transmit-ready runs a transmit phase whose length scales with the length of the frame waiting to be sent. A frame-arrival pulse while listening runs a receive phase. Both phases end by returning to the state they started from, with a one-cycle end-of-transfer pulse. Two forced commands abort an activity phase and settle into the off state or the transmit-ready state.

The register read port is combinational. The command register only accepts writes.

Top module: `xcvr_state_seq`

## Requirements
- R1: After reset the status field (bits 4:0 of register 0x01) reads 0x00 (power-up) and bits 7:5 read 0. `end_evt` is low. Reading any other register address returns 0.
- R2: A command written to bits 4:0 of register 0x02 with code 0x08 (off), 0x06 (listen), 0x09 (transmit-ready) or 0x0F (doze) is accepted when the block is steady. The status reads 0x1F for exactly SETTLE_CYC cycles, starting in the cycle after the write, and then reads the code of the target state.
- R3: The forced code 0x03 settles into status 0x08, and the forced code 0x04 settles into status 0x09. Both use the same 0x1F settle window as R2.
- R4: Command 0x02 written in state 0x09 makes the status read 0x02 from the next cycle on, for max(tx_len,1)*CYC_PER_BYTE cycles. The status then returns to 0x09, and `end_evt` is high in that first cycle back. Command 0x02 written in any other state is ignored.
- R5: A `rx_frame` pulse in state 0x06 makes the status read 0x01 for max(rx_len,1)*CYC_PER_BYTE cycles. The status then returns to 0x06, with `end_evt` high in that first cycle. A pulse in any other state is ignored.
- R6: Command codes other than 0x02, 0x03, 0x04, 0x06, 0x08, 0x09 and 0x0F are ignored, and so are writes to any address other than 0x02. The status stays unchanged.
- R7: Commands written while the status reads 0x1F are ignored. A command whose target equals the current steady state is ignored and starts no settle window.
- R8: The doze command 0x0F is accepted only from the off state 0x08. From any other steady state it is ignored.
- R9: During a 0x02 or 0x01 activity phase, the forced codes 0x03 and 0x04 abort the phase and start a settle window to their targets, and no `end_evt` is raised. All other commands written during the phase are ignored.
- R10: `end_evt` is high for one cycle at a time, and only while the status reads 0x06 or 0x09.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data. The command is in bits 4:0 |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data (status at the status address, 0 elsewhere) |
| tx_len | input | LEN_W | Length in bytes of the frame waiting to be transmitted |
| rx_frame | input | 1 | One-cycle pulse: a frame is arriving |
| rx_len | input | LEN_W | Length in bytes of the arriving frame |
| end_evt | output | 1 | One-cycle end-of-transfer pulse |

## Verification
A corrupted phase or dwell counter shows up on the status read port within the same settle or activity window. A settle window one cycle too long or too short moves the cycle in which the target code first appears, and the bench compares every one of those cycles. A wrong return state after an activity phase, or a lost or duplicated end pulse, is visible in the first cycle after the phase ends. An acceptance rule that lets an ignored command through shows a 0x1F status in the very next cycle.

// File: rtl/xcvr_state_pkg.sv
package xcvr_state_pkg;
   localparam int unsigned CODE_W = 5;

   localparam logic [CODE_W-1:0] ST_POWER_UP    = 5'h00;
   localparam logic [CODE_W-1:0] ST_RX_ACTIVE   = 5'h01;
   localparam logic [CODE_W-1:0] ST_TX_ACTIVE   = 5'h02;
   localparam logic [CODE_W-1:0] CM_FORCE_OFF   = 5'h03;
   localparam logic [CODE_W-1:0] CM_FORCE_TXRDY = 5'h04;
   localparam logic [CODE_W-1:0] ST_RX_LISTEN   = 5'h06;
   localparam logic [CODE_W-1:0] ST_OFF         = 5'h08;
   localparam logic [CODE_W-1:0] ST_TX_READY    = 5'h09;
   localparam logic [CODE_W-1:0] ST_DOZE        = 5'h0F;
   localparam logic [CODE_W-1:0] ST_MOVING      = 5'h1F;

   typedef enum logic [1:0] {
      PH_STEADY,
      PH_SETTLE,
      PH_ACTIVE
   } phase_t;

   typedef struct packed {
      logic                ok;
      logic                forced;
      logic                start_tx;
      logic [CODE_W-1:0]   target;
   } cmd_info_t;
endpackage

// File: rtl/xcvr_cmd_decode.sv
module xcvr_cmd_decode
   import xcvr_state_pkg::*;
(
   input  logic [CODE_W-1:0] code,
   output cmd_info_t         info
);
   always_comb begin
      info = '{ok: 1'b0, forced: 1'b0, start_tx: 1'b0, target: ST_POWER_UP};
      unique case (code)
         ST_OFF, ST_RX_LISTEN, ST_TX_READY, ST_DOZE: begin
            info.ok     = 1'b1;
            info.target = code;
         end
         CM_FORCE_OFF: begin
            info.ok     = 1'b1;
            info.forced = 1'b1;
            info.target = ST_OFF;
         end
         CM_FORCE_TXRDY: begin
            info.ok     = 1'b1;
            info.forced = 1'b1;
            info.target = ST_TX_READY;
         end
         ST_TX_ACTIVE: begin
            info.ok       = 1'b1;
            info.start_tx = 1'b1;
            info.target   = ST_TX_ACTIVE;
         end
         default: info.ok = 1'b0;
      endcase
   end
endmodule

// File: rtl/xcvr_len_scale.sv
module xcvr_len_scale #(
   parameter int unsigned LEN_W        = 8,
   parameter int unsigned CYC_PER_BYTE = 2,
   parameter int unsigned OUT_W        = 10
) (
   input  logic [LEN_W-1:0] len,
   output logic [OUT_W-1:0] cycles
);
   localparam int unsigned SHIFT = $clog2(CYC_PER_BYTE);
   localparam bit          POW2  = ((1 << SHIFT) == CYC_PER_BYTE);

   logic [LEN_W-1:0] len_min1;
   assign len_min1 = (len == '0) ? LEN_W'(1) : len;

   generate
      if (POW2) begin : g_shift
         assign cycles = OUT_W'(len_min1) << SHIFT;
      end else begin : g_mult
         assign cycles = OUT_W'(len_min1) * OUT_W'(CYC_PER_BYTE);
      end
   endgenerate
endmodule

// File: rtl/xcvr_dwell_timer.sv
module xcvr_dwell_timer #(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_cycles,
   output logic             expired
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_cycles - CNT_W'(1);
      end else if (cnt != '0) begin
         cnt <= cnt - CNT_W'(1);
      end
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/xcvr_state_seq.sv
module xcvr_state_seq
   import xcvr_state_pkg::*;
#(
   parameter int unsigned ADDR_W       = 6,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned LEN_W        = 8,
   parameter int unsigned SETTLE_CYC   = 4,
   parameter int unsigned CYC_PER_BYTE = 2,
   parameter int unsigned CMD_ADDR     = 2,
   parameter int unsigned STAT_ADDR    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic [LEN_W-1:0]  tx_len,
   input  logic              rx_frame,
   input  logic [LEN_W-1:0]  rx_len,
   output logic              end_evt
);
   localparam int unsigned SCALE_W  = LEN_W + $clog2(CYC_PER_BYTE + 1);
   localparam int unsigned SETTLE_W = $clog2(SETTLE_CYC + 1);
   localparam int unsigned CNT_W    = (SCALE_W > SETTLE_W) ? SCALE_W : SETTLE_W;

   generate
      if (DATA_W < CODE_W) begin : g_bad_data_w
         $error("xcvr_state_seq: DATA_W must hold a state code");
      end
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("xcvr_state_seq: SETTLE_CYC must be at least 1");
      end
      if (CYC_PER_BYTE < 1) begin : g_bad_cpb
         $error("xcvr_state_seq: CYC_PER_BYTE must be at least 1");
      end
      if (CMD_ADDR == STAT_ADDR || CMD_ADDR >= (1 << ADDR_W) || STAT_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("xcvr_state_seq: register addresses must be distinct and in range");
      end
   endgenerate

   phase_t            phase;
   logic [CODE_W-1:0] cur;
   logic [CODE_W-1:0] tgt;
   logic [CODE_W-1:0] stat_code;

   cmd_info_t         info;
   logic              cmd_hit;
   logic              go_settle, go_tx, go_rx, abort;
   logic              timer_load, expired;
   logic [LEN_W-1:0]  len_sel;
   logic [SCALE_W-1:0] act_cycles;
   logic [CNT_W-1:0]  load_cycles;

   xcvr_cmd_decode u_dec (
      .code (wr_data[CODE_W-1:0]),
      .info (info)
   );

   assign cmd_hit = wr_en && (wr_addr == ADDR_W'(CMD_ADDR));

   always_comb begin
      go_settle = 1'b0;
      go_tx     = 1'b0;
      go_rx     = 1'b0;
      abort     = 1'b0;
      unique case (phase)
         PH_STEADY: begin
            go_tx     = cmd_hit && info.start_tx && (cur == ST_TX_READY);
            go_settle = cmd_hit && info.ok && !info.start_tx && (info.target != cur)
                        && ((info.target != ST_DOZE) || (cur == ST_OFF));
            go_rx     = rx_frame && (cur == ST_RX_LISTEN) && !go_tx && !go_settle;
         end
         PH_ACTIVE: abort = cmd_hit && info.forced;
         default: ;
      endcase
   end

   assign len_sel = go_tx ? tx_len : rx_len;

   xcvr_len_scale #(
      .LEN_W        (LEN_W),
      .CYC_PER_BYTE (CYC_PER_BYTE),
      .OUT_W        (SCALE_W)
   ) u_scale (
      .len    (len_sel),
      .cycles (act_cycles)
   );

   assign timer_load  = go_settle || go_tx || go_rx || abort;
   assign load_cycles = (go_tx || go_rx) ? CNT_W'(act_cycles) : CNT_W'(SETTLE_CYC);

   xcvr_dwell_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (timer_load),
      .load_cycles (load_cycles),
      .expired     (expired)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= PH_STEADY;
         cur     <= ST_POWER_UP;
         tgt     <= ST_POWER_UP;
         end_evt <= 1'b0;
      end else begin
         end_evt <= 1'b0;
         unique case (phase)
            PH_STEADY: begin
               if (go_settle) begin
                  phase <= PH_SETTLE;
                  tgt   <= info.target;
               end else if (go_tx) begin
                  phase <= PH_ACTIVE;
                  cur   <= ST_TX_ACTIVE;
               end else if (go_rx) begin
                  phase <= PH_ACTIVE;
                  cur   <= ST_RX_ACTIVE;
               end
            end
            PH_SETTLE: begin
               if (expired) begin
                  phase <= PH_STEADY;
                  cur   <= tgt;
               end
            end
            PH_ACTIVE: begin
               if (abort) begin
                  phase <= PH_SETTLE;
                  tgt   <= info.target;
               end else if (expired) begin
                  phase   <= PH_STEADY;
                  cur     <= (cur == ST_TX_ACTIVE) ? ST_TX_READY : ST_RX_LISTEN;
                  end_evt <= 1'b1;
               end
            end
            default: phase <= PH_STEADY;
         endcase
      end
   end

   assign stat_code = (phase == PH_SETTLE) ? ST_MOVING : cur;
   assign rd_data   = (rd_addr == ADDR_W'(STAT_ADDR)) ? DATA_W'(stat_code) : '0;
endmodule

// File: rtl/xcvr_state_seq_chk.sv
module xcvr_state_seq_chk #(
   parameter int unsigned ADDR_W     = 6,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned SETTLE_CYC = 4,
   parameter int unsigned CMD_ADDR   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              rx_frame,
   input logic              end_evt,
   input logic [4:0]        stat_code
);
   localparam int unsigned RUN_W = $clog2(SETTLE_CYC + 2) + 1;

   logic [RUN_W-1:0] mv_run;
   logic             cmd_wr;
   logic             unknown_code;

   always_ff @(posedge clk) begin
      if (!rst_n) mv_run <= '0;
      else if (stat_code == 5'h1F) mv_run <= mv_run + RUN_W'(1);
      else mv_run <= '0;
   end

   assign cmd_wr = wr_en && (wr_addr == ADDR_W'(CMD_ADDR));
   assign unknown_code = !(wr_data[4:0] inside {5'h02, 5'h03, 5'h04, 5'h06, 5'h08, 5'h09, 5'h0F});

   // R10
   a_r10_end_single: assert property (@(posedge clk) disable iff (!rst_n)
      end_evt |=> !end_evt);
   a_r10_end_state: assert property (@(posedge clk) disable iff (!rst_n)
      end_evt |-> (stat_code == 5'h06 || stat_code == 5'h09));
   // R2
   a_r2_settle_len: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_code != 5'h1F && mv_run != '0) |-> (mv_run == RUN_W'(SETTLE_CYC)));
   a_r2_settle_bound: assert property (@(posedge clk) disable iff (!rst_n)
      mv_run <= RUN_W'(SETTLE_CYC));
   a_r2_settle_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_code == 5'h1F && $past(stat_code) != 5'h1F) |-> $past(cmd_wr));
   // R4
   a_r4_tx_from_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_code == 5'h02 && $past(stat_code) != 5'h02) |-> ($past(stat_code) == 5'h09));
   // R5
   a_r5_rx_from_listen: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_code == 5'h01 && $past(stat_code) != 5'h01) |-> ($past(stat_code) == 5'h06));
   // R6
   a_r6_unknown_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && unknown_code && !rx_frame
       && !(stat_code inside {5'h01, 5'h02, 5'h1F})) |=> $stable(stat_code));
endmodule

bind xcvr_state_seq xcvr_state_seq_chk #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .SETTLE_CYC (SETTLE_CYC),
   .CMD_ADDR   (CMD_ADDR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .rx_frame  (rx_frame),
   .end_evt   (end_evt),
   .stat_code (stat_code)
);

// File: tb/test_xcvr_state_seq.sv
`timescale 1ns/1ps
module test_xcvr_state_seq;
   localparam int S   = 4;
   localparam int CPB = 2;

   typedef struct {
      logic [4:0] stat;
      logic       ev;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [5:0] wr_addr = 6'h02;
   logic [7:0] wr_data = '0;
   logic [5:0] rd_addr = 6'h01;
   logic [7:0] rd_data;
   logic [7:0] tx_len = '0;
   logic       rx_frame = 1'b0;
   logic [7:0] rx_len = '0;
   logic       end_evt;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   exp_t q[$];
   logic [4:0] m_st;

   always #4 clk = ~clk;

   xcvr_state_seq #(
      .SETTLE_CYC (S),
      .CYC_PER_BYTE (CPB)
   ) i_xcvr_state_seq (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
      .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data),
      .tx_len (tx_len), .rx_frame (rx_frame), .rx_len (rx_len), .end_evt (end_evt)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic push(input logic [4:0] st, input logic ev, input string tag, input int n);
      for (int i = 0; i < n; i++) q.push_back('{stat: st, ev: ev, tag: tag});
   endtask

   // monitor: compares one expected item per cycle
   always @(negedge clk) begin
      if (rst_n && q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         chk(rd_data == {3'b000, e.stat}, {e.tag, " status"}, rd_data, e.stat);
         chk(end_evt == e.ev, {e.tag, " end_evt"}, end_evt, e.ev);
      end
   end

   task automatic drain();
      while (q.size() != 0) @(negedge clk);
   endtask

   function automatic logic [4:0] tgt_of(input logic [4:0] c);
      case (c)
         5'h03: return 5'h08;
         5'h04: return 5'h09;
         default: return c;
      endcase
   endfunction

   // steady-state command: model decides accept or ignore
   task automatic send_cmd(input logic [4:0] code, input string tag);
      bit known, acc;
      known = code inside {5'h03, 5'h04, 5'h06, 5'h08, 5'h09, 5'h0F};
      acc = known && (tgt_of(code) != m_st) && (code != 5'h0F || m_st == 5'h08);
      @(negedge clk); #1;
      wr_en = 1'b1; wr_addr = 6'h02; wr_data = {3'b000, code};
      if (acc) begin
         push(5'h1F, 1'b0, tag, S);
         m_st = tgt_of(code);
         push(m_st, 1'b0, tag, 2);
      end else begin
         push(m_st, 1'b0, tag, 3);
      end
      @(negedge clk); #1; wr_en = 1'b0;
      drain();
   endtask

   task automatic send_tx(input int len, input string tag);
      @(negedge clk); #1;
      wr_en = 1'b1; wr_addr = 6'h02; wr_data = 8'h02; tx_len = 8'(len);
      if (m_st == 5'h09) begin
         push(5'h02, 1'b0, tag, ((len == 0) ? 1 : len) * CPB);
         push(5'h09, 1'b1, tag, 1);
         push(5'h09, 1'b0, tag, 1);
      end else begin
         push(m_st, 1'b0, tag, 3);
      end
      @(negedge clk); #1; wr_en = 1'b0;
      drain();
   endtask

   task automatic send_rx(input int len, input string tag);
      @(negedge clk); #1;
      rx_frame = 1'b1; rx_len = 8'(len);
      if (m_st == 5'h06) begin
         push(5'h01, 1'b0, tag, ((len == 0) ? 1 : len) * CPB);
         push(5'h06, 1'b1, tag, 1);
         push(5'h06, 1'b0, tag, 1);
      end else begin
         push(m_st, 1'b0, tag, 3);
      end
      @(negedge clk); #1; rx_frame = 1'b0;
      drain();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      m_st = 5'h00;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(rd_data == 8'h00, "R1 reset status", rd_data, 0);
      chk(end_evt == 1'b0, "R1 reset end_evt", end_evt, 0);

      send_cmd(5'h0A, "R6 unknown code");
      send_cmd(5'h0F, "R8 doze from power-up");
      send_cmd(5'h08, "R2 to off");
      send_cmd(5'h08, "R7 same target");

      @(negedge clk); #1 rd_addr = 6'h05; #2;
      chk(rd_data == 8'h00, "R1 other address", rd_data, 0);
      #1 rd_addr = 6'h01;

      send_cmd(5'h0F, "R8 doze from off");
      send_cmd(5'h08, "R2 doze to off");
      send_tx(3, "R4 tx outside ready");
      send_cmd(5'h04, "R3 forced tx-ready");

      // write of a valid code to a non-command address
      @(negedge clk); #1;
      wr_en = 1'b1; wr_addr = 6'h03; wr_data = 8'h06;
      push(m_st, 1'b0, "R6 wrong address", 3);
      @(negedge clk); #1; wr_en = 1'b0; wr_addr = 6'h02;
      drain();

      send_tx(3, "R4 tx len3 R10");
      send_tx(0, "R4 tx len0");
      send_cmd(5'h06, "R2 to listen");
      send_rx(2, "R5 rx len2 R10");

      // R7: write during settle window ignored
      @(negedge clk); #1;
      wr_en = 1'b1; wr_data = 8'h09;
      push(5'h1F, 1'b0, "R7 write in settle", S);
      push(5'h09, 1'b0, "R7 write in settle", 2);
      m_st = 5'h09;
      @(negedge clk); #1 wr_data = 8'h08;
      @(negedge clk); #1 wr_en = 1'b0;
      drain();

      // R9: non-forced ignored in busy, forced aborts without end_evt
      @(negedge clk); #1;
      wr_en = 1'b1; wr_data = 8'h02; tx_len = 8'd10;
      push(5'h02, 1'b0, "R9 abort busy", 3);
      push(5'h1F, 1'b0, "R9 abort busy", S);
      push(5'h08, 1'b0, "R9 abort busy", 2);
      m_st = 5'h08;
      @(negedge clk); #1 wr_data = 8'h06;
      @(negedge clk); #1 wr_en = 1'b0;
      @(negedge clk); #1 begin wr_en = 1'b1; wr_data = 8'h03; end
      @(negedge clk); #1 wr_en = 1'b0;
      drain();

      send_rx(4, "R5 rx outside listen");
      send_cmd(5'h04, "R3 forced tx-ready again");
      send_cmd(5'h03, "R3 forced off");

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule